// File: doc/BRIEF.md
# Turn-Synchronous Pattern Sequencer

The block plays back a stored table of 16-bit words, one word per bunch-crossing clock, so that any bit of the output bus can be placed at any crossing within a machine turn. A host loads the table through a small register port, selects a playback mode and a start source, and then arms the block. When the selected start event arrives, the block walks the table from address 0 up to a programmable end address. In one-shot mode it then returns to idle. In continuous mode it wraps back to 0 and repeats until the host stops it.

The pattern bus leaves through one output register. While the block runs, that register takes either the table word or a fixed value held in a host register. When the block does not run, the bus is zero. `pat_valid_o` marks the cycles that carry a played word. The stream has no ready input, because playback is locked to the crossing clock and cannot stall: the consumer must take every word on the cycle it appears.

The host port takes one access per `h_req` cycle and is never back-pressured. Read data returns on the next cycle, with `h_rvalid`. The host can read a shadow copy of the playback address without disturbing playback.

Top module: `turn_pattern_seq`

Register map (`h_addr`): 0 control on write / status on read, 1 configuration, 2 memory pointer, 3 memory data, 4 end address, 5 fixed value, 6 shadow address (read only), 7 reads as zero.

## Requirements
- R1: After reset the block is idle. The pattern bus, `pat_valid_o` and the sticky error bit are 0, and status reads 0.
- R2: Writing control with bit 0 set moves an idle block to armed. Status bits [1:0] encode the state: 0 idle, 1 armed, 2 running.
- R3: Configuration bits [1:0] pick the start source: 0 `turn_i`, 1 `pre_i`, 2 a control write with bit 2 set. While the block is armed, an event from a source that is not selected is ignored and the block stays armed.
- R4: If the start event is sampled at clock edge k, the block runs from edge k on. The word at address n appears on the pattern bus after edge k+1+n, with `pat_valid_o` high.
- R5: With configuration bit 2 clear (one-shot), the cycle after the word at the end address (register 4) shows 0 on the bus with `pat_valid_o` low, and the block is idle.
- R6: With configuration bit 2 set (continuous), the word at address 0 follows the word at the end address, and this repeats.
- R7: With configuration bit 3 set, a running block drives the fixed-value register (5) on the bus instead of table words.
- R8: Writing control with bit 1 set returns the block to idle at that clock edge from any state. The bus and `pat_valid_o` are 0 in the following cycle.
- R9: Writing the data register (3) stores the low 16 bits at the pointer (register 2). Reading it returns the word at the pointer one cycle later. Both accesses advance the pointer by one.
- R10: A data-register access while running leaves the table and the pointer unchanged, reads as 0, and sets status bit 2. Writing control with bit 3 set clears that bit.
- R11: Reading register 6 returns the table address of the word that was on the pattern bus just before the read edge. Playback continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turn_i | input | 1 | Turn-marker start event |
| pre_i | input | 1 | Pre-pulse start event |
| h_req | input | 1 | Host access strobe, one access per cycle |
| h_wr | input | 1 | 1 for write, 0 for read |
| h_addr | input | 3 | Host register select |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the request |
| h_rvalid | output | 1 | Marks valid `h_rdata` |
| pat_o | output | 16 | Registered pattern bus |
| pat_valid_o | output | 1 | Pattern bus carries a played word |

## Verification
The bench builds the block with a 64-word table (AW=6). This puts the pointer wrap and any end address within a short run. Directed phases load the table, play it in one-shot mode from the turn marker, play it in continuous mode from a host start with a 4-word loop, and play the fixed value from a pre-pulse. In between they stop the block, start it from the wrong source, and access the table during playback. A behavioural model tracks the bus and host reads on every clock, and the bench compares the design against it each cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } tps_state_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CFG    = 3'd1;
  localparam logic [2:0] A_PTR    = 3'd2;
  localparam logic [2:0] A_DATA   = 3'd3;
  localparam logic [2:0] A_END    = 3'd4;
  localparam logic [2:0] A_FIXED  = 3'd5;
  localparam logic [2:0] A_SHADOW = 3'd6;

  localparam int B_ARM  = 0;
  localparam int B_STOP = 1;
  localparam int B_GO   = 2;
  localparam int B_CLR  = 3;

  localparam logic [1:0] SRC_TURN = 2'd0;
  localparam logic [1:0] SRC_PRE  = 2'd1;
  localparam logic [1:0] SRC_HOST = 2'd2;
endpackage

// File: rtl/tps_mem.sv
module tps_mem #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[wa_i] <= wd_i;
  end

  assign rd_o = store[ra_i];
endmodule

// File: rtl/tps_fsm.sv
module tps_fsm
  import tps_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic          go_i,
  input  logic          turn_i,
  input  logic          pre_i,
  input  logic [1:0]    src_i,
  input  logic          cont_i,
  input  logic [AW-1:0] end_i,
  output tps_state_e    state_o,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] shadow_o,
  output logic          run_en_o
);
  tps_state_e    state_q;
  logic [AW-1:0] cnt_q, shadow_q;
  logic          ev;
  logic          at_end;

  always_comb begin
    unique case (src_i)
      SRC_TURN: ev = turn_i;
      SRC_PRE:  ev = pre_i;
      SRC_HOST: ev = go_i;
      default:  ev = 1'b0;
    endcase
  end

  assign at_end   = (cnt_q >= end_i);
  assign run_en_o = (state_q == ST_RUN) && !stop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (arm_i) state_q <= ST_ARMED;
        ST_ARMED: if (ev) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (at_end) begin
            cnt_q <= '0;
            if (!cont_i) state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shadow_q <= '0;
    else if (run_en_o) shadow_q <= cnt_q;
  end

  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
  assign shadow_o = shadow_q;

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> state_q == ST_IDLE);
  // R4
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && ev && !stop_i) |=> (state_q == ST_RUN && cnt_q == '0));
  // R3
  hold_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !ev && !stop_i) |=> state_q == ST_ARMED);
  // R5
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_o && at_end && !cont_i) |=> state_q == ST_IDLE);
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_o && at_end && cont_i) |=> (state_q == ST_RUN && cnt_q == '0));
endmodule

// File: rtl/tps_hostregs.sv
module tps_hostregs
  import tps_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_wr,
  input  logic [2:0]    h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          h_rvalid,
  input  tps_state_e    state_i,
  input  logic [AW-1:0] shadow_i,
  input  logic [DW-1:0] mem_rd_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_wa_o,
  output logic [DW-1:0] mem_wd_o,
  output logic          arm_o,
  output logic          stop_o,
  output logic          go_o,
  output logic [1:0]    src_o,
  output logic          cont_o,
  output logic          fsel_o,
  output logic [AW-1:0] end_o,
  output logic [DW-1:0] fixed_o
);
  logic          wr, rd, wr_ctrl, running, data_acc, data_ok, clr;
  logic [3:0]    cfg_q;
  logic [AW-1:0] ptr_q, end_q;
  logic [DW-1:0] fixed_q;
  logic          err_q;
  logic [31:0]   rd_mux;
  logic          unused_wbits;

  assign unused_wbits = ^h_wdata;
  assign wr       = h_req && h_wr;
  assign rd       = h_req && !h_wr;
  assign wr_ctrl  = wr && (h_addr == A_CTRL);
  assign running  = (state_i == ST_RUN);
  assign data_acc = h_req && (h_addr == A_DATA);
  assign data_ok  = data_acc && !running;

  assign arm_o  = wr_ctrl && h_wdata[B_ARM];
  assign stop_o = wr_ctrl && h_wdata[B_STOP];
  assign go_o   = wr_ctrl && h_wdata[B_GO];
  assign clr    = wr_ctrl && h_wdata[B_CLR];

  assign mem_we_o = data_ok && h_wr;
  assign mem_wa_o = ptr_q;
  assign mem_wd_o = h_wdata[DW-1:0];

  assign src_o   = cfg_q[1:0];
  assign cont_o  = cfg_q[2];
  assign fsel_o  = cfg_q[3];
  assign end_o   = end_q;
  assign fixed_o = fixed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ptr_q   <= '0;
      end_q   <= '0;
      fixed_q <= '0;
    end else if (wr) begin
      unique case (h_addr)
        A_CFG:   cfg_q   <= h_wdata[3:0];
        A_PTR:   ptr_q   <= h_wdata[AW-1:0];
        A_END:   end_q   <= h_wdata[AW-1:0];
        A_FIXED: fixed_q <= h_wdata[DW-1:0];
        A_DATA:  if (data_ok) ptr_q <= ptr_q + 1'b1;
        default: ;
      endcase
    end else if (data_ok) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (data_acc && running) err_q <= 1'b1;
    else if (clr) err_q <= 1'b0;
  end

  always_comb begin
    unique case (h_addr)
      A_CTRL:   rd_mux = {29'd0, err_q, state_i};
      A_CFG:    rd_mux = {28'd0, cfg_q};
      A_PTR:    rd_mux = 32'(ptr_q);
      A_DATA:   rd_mux = running ? 32'd0 : 32'(mem_rd_i);
      A_END:    rd_mux = 32'(end_q);
      A_FIXED:  rd_mux = 32'(fixed_q);
      A_SHADOW: rd_mux = 32'(shadow_i);
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata  <= '0;
      h_rvalid <= 1'b0;
    end else begin
      h_rvalid <= rd;
      if (rd) h_rdata <= rd_mux;
    end
  end

  // R10
  run_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && running) |=> err_q);
  // R10
  run_access_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && running) |=> $stable(ptr_q));
  // R9
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> h_rvalid);
endmodule

// File: rtl/tps_out.sv
module tps_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en_i,
  input  logic          fsel_i,
  input  logic [DW-1:0] fixed_i,
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] pat_o,
  output logic          valid_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_o   <= '0;
      valid_o <= 1'b0;
    end else if (run_en_i) begin
      pat_o   <= fsel_i ? fixed_i : mem_i;
      valid_o <= 1'b1;
    end else begin
      pat_o   <= '0;
      valid_o <= 1'b0;
    end
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_i |=> (pat_o == '0 && !valid_o));
  // R7
  fixed_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_i && fsel_i) |=> pat_o == $past(fixed_i));
endmodule

// File: rtl/turn_pattern_seq.sv
module turn_pattern_seq
  import tps_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          turn_i,
  input  logic          pre_i,
  input  logic          h_req,
  input  logic          h_wr,
  input  logic [2:0]    h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          h_rvalid,
  output logic [DW-1:0] pat_o,
  output logic          pat_valid_o
);
  tps_state_e    state;
  logic [AW-1:0] cnt, shadow, mem_wa, mem_ra, end_a;
  logic [DW-1:0] mem_rd, mem_wd, fixed_v;
  logic          mem_we, arm, stop, go, cont, fsel, run_en;
  logic [1:0]    src;

  assign mem_ra = (state == ST_RUN) ? cnt : mem_wa;

  tps_hostregs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .state_i(state), .shadow_i(shadow), .mem_rd_i(mem_rd),
    .mem_we_o(mem_we), .mem_wa_o(mem_wa), .mem_wd_o(mem_wd),
    .arm_o(arm), .stop_o(stop), .go_o(go), .src_o(src), .cont_o(cont),
    .fsel_o(fsel), .end_o(end_a), .fixed_o(fixed_v)
  );

  tps_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .stop_i(stop), .go_i(go),
    .turn_i(turn_i), .pre_i(pre_i), .src_i(src), .cont_i(cont), .end_i(end_a),
    .state_o(state), .cnt_o(cnt), .shadow_o(shadow), .run_en_o(run_en)
  );

  tps_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we_i(mem_we), .wa_i(mem_wa), .wd_i(mem_wd),
    .ra_i(mem_ra), .rd_o(mem_rd)
  );

  tps_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .fsel_i(fsel),
    .fixed_i(fixed_v), .mem_i(mem_rd), .pat_o(pat_o), .valid_o(pat_valid_o)
  );

  // R10
  no_run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> !mem_we);
endmodule

// File: tb/turn_pattern_seq_bench.sv
`timescale 1ns/1ps
module turn_pattern_seq_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, turn_i = 0, pre_i = 0;
  logic h_req = 0, h_wr = 0;
  logic [2:0] h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic h_rvalid;
  logic [15:0] pat_o;
  logic pat_valid_o;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  turn_pattern_seq #(.AW(AW), .DW(16)) u_turn_pattern_seq (
    .clk(clk), .rst_n(rst_n), .turn_i(turn_i), .pre_i(pre_i),
    .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid), .pat_o(pat_o), .pat_valid_o(pat_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state = 0, m_cnt = 0, m_ptr = 0, m_end = 0, m_src = 0, m_shadow = 0;
  bit m_cont = 0, m_fsel = 0, m_err = 0, m_val = 0, m_rvalid = 0;
  logic [15:0] m_pat = 0, m_fixed = 0;
  logic [31:0] m_rdata = 0;
  logic [15:0] m_mem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_ptr = 0; m_end = 0; m_src = 0; m_shadow = 0;
      m_cont = 0; m_fsel = 0; m_err = 0; m_val = 0; m_pat = 0; m_fixed = 0;
      m_rvalid = 0; m_rdata = 0;
    end else begin
      bit wr, rd, run, stp, arm, go, ev;
      int ns, nc;
      wr = h_req && h_wr; rd = h_req && !h_wr; run = (m_state == 2);
      stp = wr && h_addr == 0 && h_wdata[1];
      arm = wr && h_addr == 0 && h_wdata[0];
      go  = wr && h_addr == 0 && h_wdata[2];
      ev  = (m_src == 0) ? turn_i : (m_src == 1) ? pre_i : (m_src == 2) ? go : 1'b0;
      if (rd) begin
        case (h_addr)
          0: m_rdata = {29'd0, m_err, 2'(m_state)};
          1: m_rdata = {28'd0, m_fsel, m_cont, 2'(m_src)};
          2: m_rdata = m_ptr;
          3: m_rdata = run ? 0 : (m_mem.exists(m_ptr) ? 32'(m_mem[m_ptr]) : 0);
          4: m_rdata = m_end;
          5: m_rdata = 32'(m_fixed);
          6: m_rdata = m_shadow;
          default: m_rdata = 0;
        endcase
      end
      m_rvalid = rd;
      if (run && !stp) begin
        m_pat = m_fsel ? m_fixed : (m_mem.exists(m_cnt) ? m_mem[m_cnt] : 16'h0);
        m_val = 1; m_shadow = m_cnt;
      end else begin
        m_pat = 0; m_val = 0;
      end
      if (h_req && h_addr == 3) begin
        if (run) m_err = 1;
        else begin
          if (wr) m_mem[m_ptr] = h_wdata[15:0];
          m_ptr = (m_ptr + 1) % DEPTH;
        end
      end else if (wr) begin
        case (h_addr)
          1: begin m_src = h_wdata[1:0]; m_cont = h_wdata[2]; m_fsel = h_wdata[3]; end
          2: m_ptr = h_wdata % DEPTH;
          4: m_end = h_wdata % DEPTH;
          5: m_fixed = h_wdata[15:0];
          0: if (h_wdata[3]) m_err = 0;
          default: ;
        endcase
      end
      ns = m_state; nc = m_cnt;
      if (stp) ns = 0;
      else if (m_state == 0 && arm) ns = 1;
      else if (m_state == 1 && ev) begin ns = 2; nc = 0; end
      else if (m_state == 2) begin
        if (m_cnt >= m_end) begin nc = 0; if (!m_cont) ns = 0; end
        else nc = m_cnt + 1;
      end
      m_state = ns; m_cnt = nc;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 bus", {15'd0, pat_valid_o, pat_o}, {15'd0, m_val, m_pat});
      if (m_rvalid) chk("R9 rdata", h_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); h_req = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_req = 0; h_wr = 0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); h_req = 1; h_wr = 0; h_addr = a;
    @(negedge clk); h_req = 0; d = h_rdata;
  endtask

  task automatic pulse(input bit use_pre);
    @(negedge clk); if (use_pre) pre_i = 1; else turn_i = 1;
    @(negedge clk); pre_i = 0; turn_i = 0;
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pat", {15'd0, pat_valid_o, pat_o}, 0);
    hr(0, d); chk("R1 status", d, 0);

    // R9 load and read back
    hw(2, 0);
    for (int i = 0; i < 16; i++) hw(3, 32'hA000 + i);
    hr(2, d); chk("R9 ptr advance", d, 16);
    hw(2, 0);
    for (int i = 0; i < 3; i++) begin hr(3, d); chk("R9 readback", d, 32'hA000 + i); end

    // R2, R3, R4, R5 one-shot from turn marker
    hw(4, 5); hw(1, 0);
    hw(0, 1); hr(0, d); chk("R2 armed", d, 1);
    pulse(1); hr(0, d); chk("R3 wrong source ignored", d, 1);
    pulse(0);
    chk("R4 first cycle empty", {15'd0, pat_valid_o, pat_o}, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk("R4 word", {15'd0, pat_valid_o, pat_o}, {15'd1, 16'hA000 + 16'(i)});
    end
    @(negedge clk); chk("R5 after end", {15'd0, pat_valid_o, pat_o}, 0);
    hr(0, d); chk("R5 idle", d, 0);

    // R6 continuous from host start
    hw(4, 3); hw(1, 6); hw(0, 1); hw(0, 4);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); chk("R6 wrap", {16'd0, pat_o}, 32'hA000 + (i % 4));
    end
    // R11 shadow read
    p = pat_o; h_req = 1; h_wr = 0; h_addr = 6;
    @(negedge clk); h_req = 0;
    chk("R11 shadow", h_rdata, 32'(p - 16'hA000));
    chk("R11 still running", {31'd0, pat_valid_o}, 1);
    // R10 access during run
    hw(3, 32'hDEAD);
    hr(0, d); chk("R10 err set", d, 6);
    hw(0, 2);
    chk("R8 stop clears bus", {15'd0, pat_valid_o, pat_o}, 0);
    hr(0, d); chk("R8 idle after stop", d, 4);
    hr(2, d); chk("R10 ptr unchanged", d, 3);
    hr(3, d); chk("R10 table unchanged", d, 32'hA003);
    hw(0, 8); hr(0, d); chk("R10 err cleared", d, 0);

    // R7 fixed value from pre-pulse
    hw(5, 32'h5A5A); hw(1, 9); hw(0, 1);
    pulse(1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R7 fixed", {15'd0, pat_valid_o, pat_o}, {15'd1, 16'h5A5A});
    end
    @(negedge clk); chk("R5 fixed end", {15'd0, pat_valid_o, pat_o}, 0);

    // R8 stop from armed
    hw(1, 0); hw(0, 1); hw(0, 2);
    hr(0, d); chk("R8 armed stop", d, 0);
    pulse(0); @(negedge clk);
    chk("R8 no start after stop", {15'd0, pat_valid_o, pat_o}, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule